// File: doc/BRIEF.md
# RMII Receive Dibit Adapter

This block sits between a PHY's nibble-wide receive datapath and a MAC that expects the two-bit reduced media-independent receive format. One 50 MHz reference clock times everything. Received nibbles go into a small elastic buffer. The buffer covers the gaps between nibble arrivals. The block then sends each nibble out as two dibits, the low pair first. At 100 Mb/s each dibit lasts one reference clock. At 10 Mb/s each dibit is repeated for ten reference clocks.

The block has two receive qualifiers. The combined carrier/data-valid output is high for carrier as well as for data. A separate data-valid output is high only while dibits are being delivered. The error output reports four conditions: a symbol error inside a packet, a false-carrier indication between packets, buffer overrun, and buffer underrun. After any in-packet error the data lines carry a fixed corrupt pattern until the packet ends. A MAC that ignores the error output therefore still sees damaged data.

Top module: `rmii_rx_adapter`

## Requirements
- R1: While reset is asserted, and on the first clocks after it is released, `rmii_crs_dv`, `rmii_rx_dv`, `rmii_rx_er` and `rmii_rxd` are all 0.
- R2: At 100 Mb/s (`speed_10`=0) each buffered nibble leaves as two dibits on consecutive clocks. The first dibit is bits [1:0] and the second is bits [3:2]. `rmii_rx_dv` stays high without a break for the whole packet.
- R3: At 10 Mb/s (`speed_10`=1) each dibit is held on `rmii_rxd` for exactly HOLD10 (default 10) clocks.
- R4: `rmii_crs_dv` is high whenever `carrier` is high (one clock later) or data is being delivered. `rmii_rx_dv` is high only while data is delivered. Carrier with no data gives `rmii_crs_dv`=1 and `rmii_rx_dv`=0.
- R5: A nibble written with `sym_err`=1 and every later nibble of the same packet are delivered as the corrupt dibit 2'b01. `rmii_rx_er`=1 is shown with each of these dibits. Earlier dibits are unaffected.
- R6: `false_car`=1 while no packet is being delivered gives, one clock later, `rmii_rx_er`=1, `rmii_rxd`=2'b10, `rmii_crs_dv`=1 and `rmii_rx_dv`=0 for as many clocks as it is held.
- R7: A nibble written while the FIFO_DEPTH-entry buffer is full is dropped. The packet is then marked bad: `rmii_rx_er`=1 and corrupt data until it ends.
- R8: If the buffer is empty at a nibble boundary while `pkt_dv` is still high, the block underruns. `rmii_rx_dv` stays high, the corrupt dibit is sent with `rmii_rx_er`=1, and the packet remains bad until it ends.
- R9: The error state is cleared when a packet ends, so the next packet is delivered clean.
- R10: A `nib_valid` strobe while `pkt_dv`=0 writes nothing and produces no data on the outputs.
- R11: Delivery starts once PRIME (default 2) nibbles are buffered, or as soon as `pkt_dv` falls with at least one nibble buffered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | 50 MHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| speed_10 | input | 1 | 1 selects 10 Mb/s dibit repetition |
| nib_valid | input | 1 | A nibble is presented on this clock |
| nib_data | input | 4 | Received nibble |
| pkt_dv | input | 1 | Nibble stream is inside a packet |
| carrier | input | 1 | Receive carrier present |
| sym_err | input | 1 | Presented nibble carries a symbol error |
| false_car | input | 1 | False-carrier event |
| rmii_crs_dv | output | 1 | Carrier or data valid |
| rmii_rx_dv | output | 1 | Data valid only |
| rmii_rxd | output | 2 | Receive dibit |
| rmii_rx_er | output | 1 | Receive error |

## Verification
The sequencer state is the nibble register, the half select, the hold counter and the bad flag. A wrong value in any of them shows up on `rmii_rxd` within one dibit period: one clock at 100 Mb/s, ten clocks at 10 Mb/s. A wrong buffer pointer or count shows up within one packet. It appears as a dibit stream that is reordered, lost or duplicated, or as a spurious underrun, and the underrun also breaks `rmii_rx_dv` or raises `rmii_rx_er`. A bad flag that stays set is visible on the first dibit of the next packet.

// File: rtl/rmii_rx_pkg.sv
package rmii_rx_pkg;
  localparam logic [1:0] FC_DIBIT = 2'b10;

  typedef struct packed {
    logic       err;
    logic [3:0] nib;
  } rx_entry_t;
endpackage

// File: rtl/rmii_rx_fifo.sv
module rmii_rx_fifo
  import rmii_rx_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push_i,
  input  rx_entry_t       wdata_i,
  input  logic            pop_i,
  output rx_entry_t       rdata_o,
  output logic [CW-1:0]   count_o,
  output logic            empty_o,
  output logic            ovf_o
);

  rx_entry_t       mem [DEPTH];
  logic [AW-1:0]   wp_q, wp_n, rp_q, rp_n;
  logic [CW-1:0]   cnt_q, cnt_n;
  logic            full, wr_en;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign wr_en   = push_i && (!full || pop_i);
  assign ovf_o   = push_i && full && !pop_i;
  assign rdata_o = mem[rp_q];
  assign count_o = cnt_q;

  always_comb begin
    wp_n  = wr_en ? step(wp_q) : wp_q;
    rp_n  = pop_i ? step(rp_q) : rp_q;
    cnt_n = cnt_q;
    case ({wr_en, pop_i})
      2'b10:   cnt_n = cnt_q + 1'b1;
      2'b01:   cnt_n = cnt_q - 1'b1;
      default: cnt_n = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp_q] <= wdata_i;
  end

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> !empty_o); // R8
  AST_OVF_KEEPS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> (cnt_q == CW'(DEPTH))); // R7

endmodule

// File: rtl/rmii_rx_serializer.sv
module rmii_rx_serializer
  import rmii_rx_pkg::*;
#(
  parameter int HOLD10 = 10,
  parameter int PRIME  = 2,
  parameter int CW     = 4,
  localparam int HW = (HOLD10 > 1) ? $clog2(HOLD10) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          speed_10_i,
  input  logic          pkt_in_i,
  input  logic          fifo_empty_i,
  input  logic [CW-1:0] fifo_count_i,
  input  rx_entry_t     fifo_rdata_i,
  input  logic          ovf_i,
  output logic          pop_o,
  output logic          active_o,
  output logic [1:0]    dibit_o,
  output logic          bad_o
);

  logic          act_q, act_n;
  logic          half_q, half_n;
  logic          wait_q, wait_n;
  logic          bad_q, bad_n;
  logic [3:0]    nib_q, nib_n;
  logic [HW-1:0] hold_q, hold_n;
  logic [HW-1:0] hold_max;
  logic          dibit_done, start, boundary;

  assign hold_max   = speed_10_i ? HW'(HOLD10 - 1) : '0;
  assign dibit_done = (hold_q == hold_max);
  assign start      = !fifo_empty_i &&
                      ((fifo_count_i >= CW'(PRIME)) || !pkt_in_i);
  assign boundary   = wait_q || (half_q && dibit_done);

  always_comb begin
    act_n  = act_q;
    half_n = half_q;
    wait_n = wait_q;
    nib_n  = nib_q;
    hold_n = hold_q;
    bad_n  = bad_q || ovf_i;
    pop_o  = 1'b0;
    if (!act_q) begin
      if (start) begin
        pop_o  = 1'b1;
        act_n  = 1'b1;
        nib_n  = fifo_rdata_i.nib;
        bad_n  = bad_q || ovf_i || fifo_rdata_i.err;
        half_n = 1'b0;
        hold_n = '0;
        wait_n = 1'b0;
      end
    end else if (boundary) begin
      if (!fifo_empty_i) begin
        pop_o  = 1'b1;
        nib_n  = fifo_rdata_i.nib;
        bad_n  = bad_q || ovf_i || fifo_rdata_i.err;
        half_n = 1'b0;
        hold_n = '0;
        wait_n = 1'b0;
      end else if (pkt_in_i) begin
        wait_n = 1'b1;
        bad_n  = 1'b1;
      end else begin
        act_n  = 1'b0;
        bad_n  = 1'b0;
        wait_n = 1'b0;
        half_n = 1'b0;
        hold_n = '0;
      end
    end else if (dibit_done) begin
      half_n = 1'b1;
      hold_n = '0;
    end else begin
      hold_n = hold_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      half_q <= 1'b0;
      wait_q <= 1'b0;
      bad_q  <= 1'b0;
      nib_q  <= '0;
      hold_q <= '0;
    end else begin
      act_q  <= act_n;
      half_q <= half_n;
      wait_q <= wait_n;
      bad_q  <= bad_n;
      nib_q  <= nib_n;
      hold_q <= hold_n;
    end
  end

  assign active_o = act_q;
  assign dibit_o  = half_q ? nib_q[3:2] : nib_q[1:0];
  assign bad_o    = bad_q;

  AST_DIBIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !wait_q && !dibit_done) |=> ($stable(nib_q) && $stable(half_q))); // R3
  AST_BAD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && bad_q) |=> (!act_q || bad_q)); // R5
  AST_OVF_MARKS_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_i |=> bad_q); // R7

endmodule

// File: rtl/rmii_rx_outstage.sv
module rmii_rx_outstage
  import rmii_rx_pkg::*;
#(
  parameter logic [1:0] CORRUPT = 2'b01
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ser_active_i,
  input  logic [1:0] ser_dibit_i,
  input  logic       ser_bad_i,
  input  logic       false_car_i,
  input  logic       crs_i,
  output logic       crs_dv_o,
  output logic       rx_dv_o,
  output logic [1:0] rxd_o,
  output logic       rx_er_o
);

  logic       crs_n, dv_n, er_n;
  logic [1:0] rxd_n;

  always_comb begin
    crs_n = crs_i;
    dv_n  = 1'b0;
    er_n  = 1'b0;
    rxd_n = 2'b00;
    if (ser_active_i) begin
      crs_n = 1'b1;
      dv_n  = 1'b1;
      er_n  = ser_bad_i;
      rxd_n = ser_bad_i ? CORRUPT : ser_dibit_i;
    end else if (false_car_i) begin
      crs_n = 1'b1;
      er_n  = 1'b1;
      rxd_n = FC_DIBIT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crs_dv_o <= 1'b0;
      rx_dv_o  <= 1'b0;
      rx_er_o  <= 1'b0;
      rxd_o    <= 2'b00;
    end else begin
      crs_dv_o <= crs_n;
      rx_dv_o  <= dv_n;
      rx_er_o  <= er_n;
      rxd_o    <= rxd_n;
    end
  end

  AST_FALSE_CAR_FMT: assert property (@(posedge clk) disable iff (!rst_n)
    (false_car_i && !ser_active_i) |=>
      (rx_er_o && !rx_dv_o && crs_dv_o && rxd_o == FC_DIBIT)); // R6
  AST_CARRIER_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    crs_i |=> crs_dv_o); // R4

endmodule

// File: rtl/rmii_rx_adapter.sv
module rmii_rx_adapter
  import rmii_rx_pkg::*;
#(
  parameter int         FIFO_DEPTH = 8,
  parameter int         PRIME      = 2,
  parameter int         HOLD10     = 10,
  parameter logic [1:0] CORRUPT    = 2'b01,
  localparam int        CW         = $clog2(FIFO_DEPTH + 1)
) (
  input  logic       clk_ref,
  input  logic       rst_n,
  input  logic       speed_10,
  input  logic       nib_valid,
  input  logic [3:0] nib_data,
  input  logic       pkt_dv,
  input  logic       carrier,
  input  logic       sym_err,
  input  logic       false_car,
  output logic       rmii_crs_dv,
  output logic       rmii_rx_dv,
  output logic [1:0] rmii_rxd,
  output logic       rmii_rx_er
);

  logic          rst_meta_q, rst_sync_q;
  logic          push, pop, empty, ovf;
  logic [CW-1:0] count;
  rx_entry_t     wdata, rdata;
  logic          ser_active, ser_bad;
  logic [1:0]    ser_dibit;

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign push      = nib_valid && pkt_dv;
  assign wdata.nib = nib_data;
  assign wdata.err = sym_err;

  rmii_rx_fifo #(.DEPTH(FIFO_DEPTH)) i_fifo (
    .clk     (clk_ref),
    .rst_n   (rst_sync_q),
    .push_i  (push),
    .wdata_i (wdata),
    .pop_i   (pop),
    .rdata_o (rdata),
    .count_o (count),
    .empty_o (empty),
    .ovf_o   (ovf)
  );

  rmii_rx_serializer #(.HOLD10(HOLD10), .PRIME(PRIME), .CW(CW)) i_ser (
    .clk          (clk_ref),
    .rst_n        (rst_sync_q),
    .speed_10_i   (speed_10),
    .pkt_in_i     (pkt_dv),
    .fifo_empty_i (empty),
    .fifo_count_i (count),
    .fifo_rdata_i (rdata),
    .ovf_i        (ovf),
    .pop_o        (pop),
    .active_o     (ser_active),
    .dibit_o      (ser_dibit),
    .bad_o        (ser_bad)
  );

  rmii_rx_outstage #(.CORRUPT(CORRUPT)) i_out (
    .clk          (clk_ref),
    .rst_n        (rst_sync_q),
    .ser_active_i (ser_active),
    .ser_dibit_i  (ser_dibit),
    .ser_bad_i    (ser_bad),
    .false_car_i  (false_car),
    .crs_i        (carrier),
    .crs_dv_o     (rmii_crs_dv),
    .rx_dv_o      (rmii_rx_dv),
    .rxd_o        (rmii_rxd),
    .rx_er_o      (rmii_rx_er)
  );

  AST_DV_WITH_CRS: assert property (@(posedge clk_ref) disable iff (!rst_sync_q)
    rmii_rx_dv |-> rmii_crs_dv); // R4
  AST_ER_CORRUPTS: assert property (@(posedge clk_ref) disable iff (!rst_sync_q)
    (rmii_rx_dv && rmii_rx_er) |-> (rmii_rxd == CORRUPT)); // R5

endmodule

// File: tb/test_rmii_rx_adapter.sv
`timescale 1ns/1ps
module test_rmii_rx_adapter;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       speed_10, nib_valid, pkt_dv, carrier, sym_err, false_car;
  logic [3:0] nib_data;
  logic       rmii_crs_dv, rmii_rx_dv, rmii_rx_er;
  logic [1:0] rmii_rxd;

  int n_chk = 0;
  int n_fail = 0;

  logic [1:0] cap_d [512];
  logic       cap_e [512];
  int cap_n, rises, fc_cnt, er_cnt, dv_no_crs;
  logic dv_prev;

  always #2 clk = ~clk;

  rmii_rx_adapter i_rmii_rx_adapter (
    .clk_ref(clk), .rst_n(rst_n), .speed_10(speed_10), .nib_valid(nib_valid),
    .nib_data(nib_data), .pkt_dv(pkt_dv), .carrier(carrier), .sym_err(sym_err),
    .false_car(false_car), .rmii_crs_dv(rmii_crs_dv), .rmii_rx_dv(rmii_rx_dv),
    .rmii_rxd(rmii_rxd), .rmii_rx_er(rmii_rx_er)
  );

  always @(negedge clk) begin
    if (rmii_rx_dv && cap_n < 512) begin
      cap_d[cap_n] = rmii_rxd;
      cap_e[cap_n] = rmii_rx_er;
      cap_n++;
    end
    if (rmii_rx_dv && !dv_prev) rises++;
    if (rmii_rx_er) er_cnt++;
    if (rmii_rx_er && !rmii_rx_dv && rmii_crs_dv && rmii_rxd == 2'b10) fc_cnt++;
    if (rmii_rx_dv && !rmii_crs_dv) dv_no_crs++;
    dv_prev = rmii_rx_dv;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [3:0] nibv(input int i, input int seed);
    return 4'((i * 7 + seed) & 15);
  endfunction

  function automatic logic [1:0] dib(input logic [3:0] n, input int half);
    return (half != 0) ? n[3:2] : n[1:0];
  endfunction

  task automatic clear_cap();
    cap_n = 0; rises = 0; fc_cnt = 0; er_cnt = 0;
  endtask

  task automatic push_nibs(input int first, input int n, input int gap,
                           input int seed, input int err_at);
    for (int i = first; i < first + n; i++) begin
      @(negedge clk);
      pkt_dv = 1'b1; nib_valid = 1'b1; nib_data = nibv(i, seed);
      sym_err = (i == err_at);
      for (int g = 1; g < gap; g++) begin
        @(negedge clk);
        nib_valid = 1'b0; sym_err = 1'b0;
      end
    end
    @(negedge clk);
    nib_valid = 1'b0; sym_err = 1'b0;
  endtask

  task automatic end_pkt();
    pkt_dv = 1'b0;
    repeat (250) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(rmii_crs_dv == 0, "R1 crs_dv", rmii_crs_dv, 0);
    chk(rmii_rx_dv == 0, "R1 rx_dv", rmii_rx_dv, 0);
    chk(rmii_rx_er == 0, "R1 rx_er", rmii_rx_er, 0);
    chk(rmii_rxd == 0, "R1 rxd", rmii_rxd, 0);
  endtask

  task automatic t_idle_strobe();
    clear_cap();
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); nib_valid = 1'b1; nib_data = 4'hF;
    end
    @(negedge clk); nib_valid = 1'b0;
    repeat (20) @(negedge clk);
    chk(cap_n == 0, "R10 no data from strobe outside packet", cap_n, 0);
  endtask

  task automatic t_basic100(input int seed);
    int bad = 0;
    clear_cap();
    push_nibs(0, 8, 2, seed, -1);
    end_pkt();
    chk(cap_n == 16, "R2 dibit count", cap_n, 16);
    for (int i = 0; i < 16; i++)
      if (cap_d[i] != dib(nibv(i / 2, seed), i % 2) || cap_e[i]) bad++;
    chk(bad == 0, "R2 dibit order lsb first", bad, 0);
    chk(rises == 1, "R2 rx_dv continuous", rises, 1);
  endtask

  task automatic t_single();
    clear_cap();
    push_nibs(0, 1, 2, 3, -1);
    repeat (6) @(negedge clk);
    chk(cap_n == 0, "R11 no start below prime level", cap_n, 0);
    end_pkt();
    chk(cap_n == 2, "R11 start after packet end", cap_n, 2);
    chk(cap_d[0] == dib(nibv(0, 3), 0) && cap_d[1] == dib(nibv(0, 3), 1),
        "R11 single nibble data", int'(cap_d[0]), int'(dib(nibv(0, 3), 0)));
  endtask

  task automatic t_10m();
    int bad = 0;
    clear_cap();
    speed_10 = 1'b1;
    push_nibs(0, 4, 20, 5, -1);
    end_pkt();
    speed_10 = 1'b0;
    chk(cap_n == 80, "R3 ten clocks per dibit", cap_n, 80);
    for (int i = 0; i < 80; i++)
      if (cap_d[i] != dib(nibv(i / 20, 5), (i / 10) % 2)) bad++;
    chk(bad == 0, "R3 repeated dibit values", bad, 0);
  endtask

  task automatic t_symerr();
    int bad = 0;
    clear_cap();
    push_nibs(0, 8, 2, 9, 3);
    end_pkt();
    chk(cap_n == 16, "R5 dibit count", cap_n, 16);
    for (int i = 0; i < 16; i++) begin
      if (i < 6) begin
        if (cap_d[i] != dib(nibv(i / 2, 9), i % 2) || cap_e[i]) bad++;
      end else begin
        if (cap_d[i] != 2'b01 || !cap_e[i]) bad++;
      end
    end
    chk(bad == 0, "R5 corrupt from error nibble on", bad, 0);
  endtask

  task automatic t_false_car();
    clear_cap();
    @(negedge clk); false_car = 1'b1;
    repeat (3) @(negedge clk);
    false_car = 1'b0;
    repeat (5) @(negedge clk);
    chk(fc_cnt == 3, "R6 false carrier indication", fc_cnt, 3);
    chk(cap_n == 0, "R6 no rx_dv on false carrier", cap_n, 0);
  endtask

  task automatic t_carrier();
    clear_cap();
    @(negedge clk); carrier = 1'b1;
    repeat (3) @(negedge clk);
    chk(rmii_crs_dv == 1, "R4 crs_dv on carrier", rmii_crs_dv, 1);
    chk(rmii_rx_dv == 0, "R4 rx_dv without data", rmii_rx_dv, 0);
    push_nibs(0, 4, 2, 1, -1);
    carrier = 1'b0;
    end_pkt();
    chk(cap_n == 8, "R4 data during carrier", cap_n, 8);
    chk(rmii_crs_dv == 0, "R4 crs_dv falls after packet", rmii_crs_dv, 0);
    chk(dv_no_crs == 0, "R4 rx_dv implies crs_dv", dv_no_crs, 0);
  endtask

  task automatic t_underrun();
    int bad = 0;
    clear_cap();
    push_nibs(0, 4, 2, 11, -1);
    repeat (12) @(negedge clk);
    push_nibs(4, 4, 2, 11, -1);
    end_pkt();
    for (int i = 0; i < 8; i++)
      if (cap_d[i] != dib(nibv(i / 2, 11), i % 2) || cap_e[i]) bad++;
    chk(bad == 0, "R8 data before underrun", bad, 0);
    chk(rises == 1, "R8 rx_dv held through underrun", rises, 1);
    chk(er_cnt > 0, "R8 rx_er on underrun", er_cnt, 1);
    chk(cap_n > 16 && cap_d[cap_n - 1] == 2'b01 && cap_e[cap_n - 1],
        "R8 corrupt until end", int'(cap_d[cap_n - 1]), 1);
  endtask

  task automatic t_overflow();
    clear_cap();
    push_nibs(0, 24, 1, 2, -1);
    end_pkt();
    chk(er_cnt > 0, "R7 rx_er on overflow", er_cnt, 1);
    chk(cap_n < 48, "R7 overflowed nibbles dropped", cap_n, 47);
    chk(cap_e[cap_n - 1] == 1 && cap_d[cap_n - 1] == 2'b01,
        "R7 corrupt at end", int'(cap_d[cap_n - 1]), 1);
  endtask

  task automatic t_recover();
    int bad = 0;
    clear_cap();
    push_nibs(0, 6, 2, 4, -1);
    end_pkt();
    chk(cap_n == 12, "R9 next packet length", cap_n, 12);
    for (int i = 0; i < 12; i++)
      if (cap_d[i] != dib(nibv(i / 2, 4), i % 2) || cap_e[i]) bad++;
    chk(bad == 0, "R9 next packet clean", bad, 0);
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    clear_cap();
    dv_no_crs = 0; dv_prev = 1'b0;
    rst_n = 1'b0; speed_10 = 1'b0; nib_valid = 1'b0; nib_data = '0;
    pkt_dv = 1'b0; carrier = 1'b0; sym_err = 1'b0; false_car = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    repeat (3) @(negedge clk);
    t_idle_strobe();
    t_basic100(0);
    t_basic100(6);
    t_single();
    t_10m();
    t_symerr();
    t_recover();
    t_false_car();
    t_carrier();
    t_underrun();
    t_recover();
    t_overflow();
    t_recover();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule